// File: doc/BRIEF.md
# Power-Aware Cache Read Controller

This block drives the tag, valid and data arrays of a four-way set-associative cache on the read path, and chooses which arrays to wake for each read. A request that starts a new line gets a full lookup. Every way's tag, valid and security entries are read, and every way's data array is enabled, but only at the addressed word. The hit way is picked one cycle later, when the synchronous RAM outputs come back. The request also carries a `seq` flag. When that flag is set and the request falls in the line that the last resolved read hit, under the same security state, the tag and valid arrays stay idle and only the data array of the remembered way is enabled.

Each stored line carries a security bit, and a lookup hits only when that bit equals the security state of the request. A miss response carries the offset of the requested word, so the refill side can fetch that word first. An invalidate-all request walks every set over successive cycles and clears the valid bits. While the walk runs the block reports busy and takes no reads.

The control is a four-state machine. `ST_IDLE` means no response is due. `ST_FULL` means a full-lookup response is due in this cycle. `ST_FAST` means a same-line response is due in this cycle. `ST_CLEAR` means the valid walk is in progress. From `ST_IDLE`, `ST_FULL` or `ST_FAST`, an invalidate moves the machine to `ST_CLEAR`. Otherwise an accepted full-lookup read moves it to `ST_FULL`, an accepted same-line read moves it to `ST_FAST`, and no accepted read moves it to `ST_IDLE`. `ST_CLEAR` stays put until the last set has been written, then returns to `ST_IDLE`.

Top module: `cache_rd_ctrl`

## Requirements
- R1: An accepted read that does not take the same-line path sets all four `tag_en` bits and all four `data_en` bits in the cycle of acceptance. In that cycle `tag_idx` equals address bits [10:5] and `data_addr` equals address bits [10:2] (set index above word offset).
- R2: An accepted read with `req_seq`=1 takes the same-line path when the last resolved response was a hit, no miss or invalidate has come since, and the request has the same tag (bits [31:11]), index and security state as that hit. On this path `tag_en` is zero and `data_en` has exactly one bit set, bit w for the way w that hit.
- R3: A read accepted in cycle n gives `resp_valid`=1 in cycle n+1, together with `resp_hit`, `resp_way` (binary way number) and `resp_data`. `resp_data` is the addressed 32-bit word of the hit way, or zero on a miss.
- R4: A way hits only when its valid bit is 1, its stored tag equals address bits [31:11], and its stored security bit equals `req_secure`.
- R5: On a miss, `resp_miss_word` equals the word offset (address bits [4:2]) of the request that missed. It is zero otherwise.
- R6: After reset, and after a miss, a read with `req_seq`=1 takes the full lookup.
- R7: A read with `req_seq`=1 whose line or security state differs from the remembered hit takes the full lookup.
- R8: `inv_req` accepted while not busy raises `busy` for exactly 64 cycles, starting the next cycle. During that window `vld_clr`=1, `vld_clr_idx` counts 0 to 63 in order, and `req_ready`=0. The remembered hit is dropped, so the next `seq` read takes the full lookup.
- R9: `req_ready` is low while busy or while `inv_req` is high. In any cycle where no read is accepted, all `tag_en` and `data_en` bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Read accepted this cycle when high |
| req_addr | input | 32 | Byte address of the read |
| req_secure | input | 1 | Security state of the request |
| req_seq | input | 1 | Request follows the previous read |
| inv_req | input | 1 | Start invalidate-all |
| busy | output | 1 | Invalidate walk in progress |
| tag_en | output | 4 | Per-way tag/valid/security array read enable |
| tag_idx | output | 6 | Set index for the tag arrays |
| tag_rd_tag | input | 84 | Per-way stored tags, 21 bits each, way 0 lowest |
| tag_rd_valid | input | 4 | Per-way stored valid bits |
| tag_rd_sec | input | 4 | Per-way stored security bits |
| vld_clr | output | 1 | Clear valid bits of all ways at `vld_clr_idx` |
| vld_clr_idx | output | 6 | Set being cleared |
| data_en | output | 4 | Per-way data array read enable |
| data_addr | output | 9 | Word address in a data array: set index, then word |
| data_rd | input | 128 | Per-way read words, 32 bits each, way 0 lowest |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Response is a hit |
| resp_way | output | 2 | Way that hit |
| resp_data | output | 32 | Word read |
| resp_miss_word | output | 3 | Word offset to fetch first on a miss |

## Verification
The hardest case to reach is a same-line read accepted in the very cycle the earlier response resolves. There the path choice depends on a hit that is only being decided in that cycle, and not on the held registers. The stimulus issues `seq` reads back to back inside one line, then changes the security state in the middle of the line, and then issues a `seq` read straight after a miss. A long random phase follows. It mostly keeps `seq` reads in the current line with random gaps, so that the forwarded decision and the held-register decision are both taken many times. The invalidate walk is entered while a response is still outstanding and while reads are being offered.

// File: rtl/rdctl_pkg.sv
package rdctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FULL,
        ST_FAST,
        ST_CLEAR
    } rdctl_state_e;
endpackage

// File: rtl/rdctl_way_match.sv
module rdctl_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 21
) (
    input  logic [WAYS*TAG_W-1:0]       rd_tag,
    input  logic [WAYS-1:0]             rd_valid,
    input  logic [WAYS-1:0]             rd_sec,
    input  logic [TAG_W-1:0]            cmp_tag,
    input  logic                        cmp_sec,
    output logic                        any_hit,
    output logic [$clog2(WAYS)-1:0]     hit_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign match[g] = rd_valid[g] && (rd_sec[g] == cmp_sec) &&
                          (rd_tag[g*TAG_W +: TAG_W] == cmp_tag);
    end

    always_comb begin
        any_hit = |match;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) hit_way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/rdctl_word_mux.sv
module rdctl_word_mux #(
    parameter int WAYS   = 4,
    parameter int DATA_W = 32
) (
    input  logic [WAYS*DATA_W-1:0]      data_in,
    input  logic [$clog2(WAYS)-1:0]     sel,
    input  logic                        keep,
    output logic [DATA_W-1:0]           data_out
);
    always_comb begin
        data_out = keep ? data_in[sel*DATA_W +: DATA_W] : '0;
    end
endmodule

// File: rtl/cache_rd_ctrl.sv
module cache_rd_ctrl
    import rdctl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 64,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int OFS_W  = $clog2(DATA_W / 8),
    localparam int WORD_W = $clog2(WORDS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - WORD_W - OFS_W,
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        req_secure,
    input  logic                        req_seq,
    input  logic                        inv_req,
    output logic                        busy,
    output logic [WAYS-1:0]             tag_en,
    output logic [IDX_W-1:0]            tag_idx,
    input  logic [WAYS*TAG_W-1:0]       tag_rd_tag,
    input  logic [WAYS-1:0]             tag_rd_valid,
    input  logic [WAYS-1:0]             tag_rd_sec,
    output logic                        vld_clr,
    output logic [IDX_W-1:0]            vld_clr_idx,
    output logic [WAYS-1:0]             data_en,
    output logic [IDX_W+WORD_W-1:0]     data_addr,
    input  logic [WAYS*DATA_W-1:0]      data_rd,
    output logic                        resp_valid,
    output logic                        resp_hit,
    output logic [WAY_W-1:0]            resp_way,
    output logic [DATA_W-1:0]           resp_data,
    output logic [WORD_W-1:0]           resp_miss_word
);
    rdctl_state_e state, state_nx;

    logic [WORD_W-1:0] rq_word;
    logic [IDX_W-1:0]  rq_idx;
    logic [TAG_W-1:0]  rq_tag;
    assign rq_word = req_addr[OFS_W +: WORD_W];
    assign rq_idx  = req_addr[OFS_W+WORD_W +: IDX_W];
    assign rq_tag  = req_addr[ADDR_W-1 -: TAG_W];

    // request in flight (resolved in the following cycle)
    logic [IDX_W-1:0]  pd_idx;
    logic [TAG_W-1:0]  pd_tag;
    logic              pd_sec;
    logic [WORD_W-1:0] pd_word;
    logic [WAY_W-1:0]  pd_way;

    // last resolved hit
    logic              hd_vld;
    logic [IDX_W-1:0]  hd_idx;
    logic [TAG_W-1:0]  hd_tag;
    logic              hd_sec;
    logic [WAY_W-1:0]  hd_way;

    logic [IDX_W-1:0]  clr_cnt;

    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;

    rdctl_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .rd_tag   (tag_rd_tag),
        .rd_valid (tag_rd_valid),
        .rd_sec   (tag_rd_sec),
        .cmp_tag  (pd_tag),
        .cmp_sec  (pd_sec),
        .any_hit  (lk_hit),
        .hit_way  (lk_way)
    );

    rdctl_word_mux #(.WAYS(WAYS), .DATA_W(DATA_W)) u_mux (
        .data_in  (data_rd),
        .sel      (resp_way),
        .keep     (resp_hit),
        .data_out (resp_data)
    );

    // response side
    always_comb begin
        resp_valid     = (state == ST_FULL) || (state == ST_FAST);
        resp_hit       = (state == ST_FAST) || ((state == ST_FULL) && lk_hit);
        resp_way       = (state == ST_FAST) ? pd_way : (lk_hit ? lk_way : '0);
        resp_miss_word = (resp_valid && !resp_hit) ? pd_word : '0;
    end

    // line the next read may reuse: the resolving response wins over the held copy
    logic              ef_vld;
    logic [IDX_W-1:0]  ef_idx;
    logic [TAG_W-1:0]  ef_tag;
    logic              ef_sec;
    logic [WAY_W-1:0]  ef_way;
    logic              accept;
    logic              go_fast;

    always_comb begin
        if (resp_valid) begin
            ef_vld = resp_hit;
            ef_idx = pd_idx;
            ef_tag = pd_tag;
            ef_sec = pd_sec;
            ef_way = resp_way;
        end else begin
            ef_vld = hd_vld;
            ef_idx = hd_idx;
            ef_tag = hd_tag;
            ef_sec = hd_sec;
            ef_way = hd_way;
        end
        req_ready = (state != ST_CLEAR) && !inv_req;
        accept    = req_valid && req_ready;
        go_fast   = accept && req_seq && ef_vld && (ef_idx == rq_idx) &&
                    (ef_tag == rq_tag) && (ef_sec == req_secure);
    end

    // output process
    always_comb begin
        tag_en      = (accept && !go_fast) ? '1 : '0;
        data_en     = accept ? (go_fast ? (WAYS'(1) << ef_way) : '1) : '0;
        tag_idx     = rq_idx;
        data_addr   = {rq_idx, rq_word};
        busy        = (state == ST_CLEAR);
        vld_clr     = (state == ST_CLEAR);
        vld_clr_idx = clr_cnt;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR: begin
                if (clr_cnt == IDX_W'(SETS - 1)) state_nx = ST_IDLE;
            end
            ST_IDLE, ST_FULL, ST_FAST: begin
                if (inv_req)      state_nx = ST_CLEAR;
                else if (go_fast) state_nx = ST_FAST;
                else if (accept)  state_nx = ST_FULL;
                else              state_nx = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                clr_cnt <= '0;
        else if (state == ST_CLEAR) clr_cnt <= clr_cnt + 1'b1;
        else                        clr_cnt <= '0;
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            pd_idx  <= rq_idx;
            pd_tag  <= rq_tag;
            pd_sec  <= req_secure;
            pd_word <= rq_word;
            pd_way  <= ef_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_vld <= 1'b0;
            hd_idx <= '0;
            hd_tag <= '0;
            hd_sec <= 1'b0;
            hd_way <= '0;
        end else if (inv_req && state != ST_CLEAR) begin
            hd_vld <= 1'b0;
        end else if (resp_valid) begin
            hd_vld <= resp_hit;
            hd_idx <= pd_idx;
            hd_tag <= pd_tag;
            hd_sec <= pd_sec;
            hd_way <= resp_way;
        end
    end

    // R9: nothing is woken unless a read is taken
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |-> (tag_en == '0 && data_en == '0));

    // R2: a data-only access touches exactly one way
    a_r2_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en != '0 && tag_en == '0) |-> $onehot(data_en));

    // R3: one-cycle response
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    // R4: a full-lookup hit has a valid, security-matching way behind it
    a_r4_sec_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && resp_hit) |->
            (tag_rd_valid[resp_way] && tag_rd_sec[resp_way] == pd_sec));

    // R8: busy blocks reads, and the walk advances one set per cycle
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    a_r8_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_clr && $past(vld_clr)) |-> (vld_clr_idx == $past(vld_clr_idx) + 1'b1));
endmodule

// File: tb/tb_cache_rd_ctrl.sv
module tb_cache_rd_ctrl;
    localparam int WAYS = 4, SETS = 64, WORDS = 8, TAG_W = 21, IDX_W = 6, WORD_W = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, req_valid, req_ready, req_secure, req_seq, inv_req, busy, vld_clr;
    logic [31:0] req_addr;
    logic [WAYS-1:0] tag_en, data_en, tag_rd_valid, tag_rd_sec;
    logic [IDX_W-1:0] tag_idx, vld_clr_idx;
    logic [WAYS*TAG_W-1:0] tag_rd_tag;
    logic [IDX_W+WORD_W-1:0] data_addr;
    logic [WAYS*32-1:0] data_rd;
    logic resp_valid, resp_hit;
    logic [1:0] resp_way;
    logic [31:0] resp_data;
    logic [WORD_W-1:0] resp_miss_word;

    cache_rd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_secure(req_secure), .req_seq(req_seq),
        .inv_req(inv_req), .busy(busy), .tag_en(tag_en), .tag_idx(tag_idx),
        .tag_rd_tag(tag_rd_tag), .tag_rd_valid(tag_rd_valid), .tag_rd_sec(tag_rd_sec),
        .vld_clr(vld_clr), .vld_clr_idx(vld_clr_idx), .data_en(data_en),
        .data_addr(data_addr), .data_rd(data_rd), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_way(resp_way), .resp_data(resp_data),
        .resp_miss_word(resp_miss_word)
    );

    // RAM arrays seen by the design
    logic [TAG_W-1:0] mem_t [WAYS][SETS];
    logic             mem_v [WAYS][SETS];
    logic             mem_s [WAYS][SETS];
    logic [31:0]      mem_d [WAYS][SETS*WORDS];

    // independent reference copy
    logic [TAG_W-1:0] ref_t [WAYS][SETS];
    logic             ref_v [WAYS][SETS];
    logic             ref_s [WAYS][SETS];
    logic [31:0]      ref_d [WAYS][SETS][WORDS];

    always @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (tag_en[w]) begin
                tag_rd_tag[w*TAG_W +: TAG_W] <= mem_t[w][tag_idx];
                tag_rd_valid[w] <= mem_v[w][tag_idx];
                tag_rd_sec[w]   <= mem_s[w][tag_idx];
            end
            if (data_en[w]) data_rd[w*32 +: 32] <= mem_d[w][data_addr];
            if (vld_clr) mem_v[w][vld_clr_idx] <= 1'b0;
        end
    end

    int vectors = 0, misses = 0;
    bit done = 0;
    string note = "";

    // model state
    bit m_busy; int m_cnt;
    bit p_v; int p_idx, p_word; logic [TAG_W-1:0] p_tag; bit p_sec;
    bit h_v; int h_idx, h_way; logic [TAG_W-1:0] h_tag; bit h_sec;

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, note, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input logic [TAG_W-1:0] t, input int s, input int k);
        return {t, IDX_W'(s), WORD_W'(k), 2'b00};
    endfunction

    task automatic fill(input int w, input int s, input logic [TAG_W-1:0] t, input bit sc, input bit v);
        mem_t[w][s] = t; ref_t[w][s] = t;
        mem_s[w][s] = sc; ref_s[w][s] = sc;
        mem_v[w][s] = v; ref_v[w][s] = v;
        for (int k = 0; k < WORDS; k++) begin
            mem_d[w][s*WORDS+k] = {t[11:0], 4'(w), 8'(s), 8'(k)} ^ 32'h5A00_0000;
            ref_d[w][s][k]      = {t[11:0], 4'(w), 8'(s), 8'(k)} ^ 32'h5A00_0000;
        end
    endtask

    task automatic step(input bit v, input logic [31:0] a, input bit sc, input bit q, input bit inv);
        bit e_hit, e_ready, acc, fast, ev; int e_way, ei, ew; logic [TAG_W-1:0] et; bit es;
        logic [31:0] e_data; int ri, rk; logic [TAG_W-1:0] rt;
        string lb;
        @(negedge clk);
        req_valid = v; req_addr = a; req_secure = sc; req_seq = q; inv_req = inv;
        #1;
        vectors++;
        ri = int'(a[10:5]); rk = int'(a[4:2]); rt = a[31:11];
        e_hit = 0; e_way = 0; e_data = 0;
        if (p_v) begin
            for (int w = 0; w < WAYS; w++)
                if (ref_v[w][p_idx] && ref_t[w][p_idx] == p_tag && ref_s[w][p_idx] == p_sec) begin
                    e_hit = 1; e_way = w;
                end
            if (e_hit) e_data = ref_d[e_way][p_idx][p_word];
        end
        chk("R3 resp_valid", 128'(resp_valid), 128'(p_v));
        if (p_v) begin
            chk("R3/R4 resp_hit", 128'(resp_hit), 128'(e_hit));
            chk("R3 resp_way", 128'(resp_way), 128'(e_way));
            chk("R3 resp_data", 128'(resp_data), 128'(e_data));
            chk("R5 resp_miss_word", 128'(resp_miss_word), 128'(e_hit ? 0 : p_word));
        end
        if (p_v) begin ev = e_hit; ei = p_idx; et = p_tag; es = p_sec; ew = e_way; end
        else begin ev = h_v; ei = h_idx; et = h_tag; es = h_sec; ew = h_way; end
        e_ready = !m_busy && !inv;
        acc = v && e_ready;
        fast = acc && q && ev && ei == ri && et == rt && es == sc;
        lb = fast ? "R2" : (q ? "R7" : "R1");
        chk("R9 req_ready", 128'(req_ready), 128'(e_ready));
        chk("R8 busy", 128'(busy), 128'(m_busy));
        chk("R8 vld_clr", 128'(vld_clr), 128'(m_busy));
        if (m_busy) chk("R8 vld_clr_idx", 128'(vld_clr_idx), 128'(m_cnt));
        chk({lb, " tag_en"}, 128'(tag_en), 128'(acc && !fast ? 4'hF : 4'h0));
        chk({lb, " data_en"}, 128'(data_en), 128'(acc ? (fast ? (4'h1 << ew) : 4'hF) : 4'h0));
        if (acc) begin
            chk("R1 tag_idx", 128'(tag_idx), 128'(ri));
            chk("R1 data_addr", 128'(data_addr), 128'({IDX_W'(ri), WORD_W'(rk)}));
        end
        // advance model
        if (inv && !m_busy) h_v = 0;
        else if (p_v) begin h_v = e_hit; h_idx = p_idx; h_tag = p_tag; h_sec = p_sec; h_way = e_way; end
        if (m_busy) begin
            if (m_cnt == SETS - 1) m_busy = 0; else m_cnt++;
        end else if (inv) begin
            m_busy = 1; m_cnt = 0;
            for (int w = 0; w < WAYS; w++) for (int s = 0; s < SETS; s++) ref_v[w][s] = 0;
        end
        p_v = acc; p_idx = ri; p_word = rk; p_tag = rt; p_sec = sc;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 32'h0, 0, 0, 0);
    endtask

    localparam logic [TAG_W-1:0] TA = 21'h0_1A2B, TB = 21'h1_0F0F, TC = 21'h0_7777, TD = 21'h1_2345;

    task automatic fill_all();
        for (int w = 0; w < WAYS; w++) for (int s = 0; s < SETS; s++) fill(w, s, 21'h1F_FFFF - 21'(w), 0, 0);
        fill(2, 3, TA, 0, 1);
        fill(0, 3, TB, 1, 1);
        fill(1, 10, TC, 0, 1);
        fill(3, 10, TD, 0, 0);
        fill(0, 5, TC, 1, 1);
        fill(3, 5, TD, 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [TAG_W-1:0] lt; int ls, lw; bit lsec;
        rst_n = 0; req_valid = 0; req_addr = 0; req_secure = 0; req_seq = 0; inv_req = 0;
        m_busy = 0; m_cnt = 0; p_v = 0; h_v = 0; h_idx = 0; h_way = 0; h_tag = 0; h_sec = 0;
        p_idx = 0; p_word = 0; p_tag = 0; p_sec = 0;
        tag_rd_tag = '0; tag_rd_valid = '0; tag_rd_sec = '0; data_rd = '0;
        fill_all();
        repeat (3) @(negedge clk);
        rst_n = 1;
        note = "reset state R6";
        idle(2);
        step(1, mk_addr(TA, 3, 1), 0, 1, 0);          // R6: seq right after reset -> full
        note = "R1/R2 same line";
        step(1, mk_addr(TA, 3, 5), 0, 0, 0);
        step(1, mk_addr(TA, 3, 6), 0, 1, 0);          // R2 forwarded
        step(1, mk_addr(TA, 3, 7), 0, 1, 0);
        note = "R4 security mismatch";
        step(1, mk_addr(TA, 3, 2), 1, 1, 0);          // R7 + R4 + R5 miss word 2
        note = "R6 seq after miss";
        step(1, mk_addr(TA, 3, 0), 0, 1, 0);
        step(1, mk_addr(TA, 3, 4), 0, 1, 0);
        note = "R7 new line";
        step(1, mk_addr(TC, 10, 3), 0, 1, 0);
        note = "R4 invalid way";
        step(1, mk_addr(TD, 10, 6), 0, 0, 0);
        idle(1);
        step(1, mk_addr(TD, 10, 1), 0, 1, 0);         // R6 held gone after miss
        note = "R2 after gap";
        step(1, mk_addr(TB, 3, 3), 1, 0, 0);
        idle(3);
        step(1, mk_addr(TB, 3, 4), 1, 1, 0);
        note = "R8 invalidate";
        step(1, mk_addr(TC, 5, 2), 1, 0, 0);
        step(1, mk_addr(TC, 5, 3), 1, 1, 1);          // inv wins, response still due
        for (int i = 0; i < 66; i++) step(1, mk_addr(TC, 5, 3), 1, 1, i == 10);
        step(1, mk_addr(TC, 5, 4), 1, 1, 0);          // R8 held dropped, miss
        idle(2);
        fill_all();
        note = "random";
        lt = TA; ls = 3; lsec = 0;
        for (int i = 0; i < 3000; i++) begin
            bit v, q;
            int pick;
            v = ($urandom % 4) != 0;
            q = ($urandom % 4) != 0;
            if (!q || ($urandom % 5) == 0) begin
                pick = $urandom % 6;
                case (pick)
                    0: begin lt = TA; ls = 3; end
                    1: begin lt = TB; ls = 3; end
                    2: begin lt = TC; ls = 10; end
                    3: begin lt = TD; ls = 10; end
                    4: begin lt = TC; ls = 5; end
                    default: begin lt = TD; ls = 5; end
                endcase
                lsec = ($urandom % 3) == 0;
            end
            lw = $urandom % WORDS;
            step(v, mk_addr(lt, ls, lw), lsec, q, 0);
        end
        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule